// File: doc/BRIEF.md
# Virtualized Interrupt Route Decoder

This block is the routing stage for external I/O interrupt lines. Each source has a level input, an enable bit and a 12-bit route entry. The entry holds an 8-bit CPU selector and a 4-bit pin selector. On each clock the lowest-numbered source that is enabled and asserted, and that has not yet been serviced, is selected. Its route entry is decoded into a target CPU number and an interrupt pin number, and the result is presented as a registered event strobe.

A feature register, which software cannot change, reports that both binary-encoded selection methods are available. A configuration register chooses at run time how each selector is read. After reset both selectors are read as bitmaps, which reaches four CPUs in each of four nodes and pins 0 to 3. Setting the CPU bit makes the 8-bit selector a plain index over 256 CPUs. Setting the pin bit makes the 4-bit selector a plain index over 16 pins.

In bitmap mode a selector with no bit set cannot be routed. The event is dropped and a sticky error flag is raised.

All registers are reached through a small word-wide read/write bus. Read data is returned one cycle after the read strobe.

Top module: `vroute_top`

## Requirements
- R1: Address 0 is the feature word and always reads 0x3 (bit 0 pin encoding available, bit 1 CPU encoding available). Writes to it change nothing.
- R2: Address 1 is the configuration word. It resets to 0 (bitmap for both fields). Bit 0 selects the encoded pin method, bit 1 selects the encoded CPU method, and both read back as written.
- R3: With configuration bit 1 clear, the CPU index is node*4+cpu. Node is the lowest set bit of entry bits [7:4] and cpu is the lowest set bit of entry bits [3:0], so the index is below 16.
- R4: With configuration bit 0 clear, the pin index is the lowest set bit of entry bits [11:8], a value from 0 to 3.
- R5: With configuration bit 0 set, the pin index equals entry bits [11:8].
- R6: With configuration bit 1 set, the CPU index equals entry bits [7:0].
- R7: A bitmap-read selector whose relevant bits are all zero produces no event and sets the error output. The error output stays set until any write to address 3. A new error in the same cycle as that write keeps it set. Address 3 reads the flag on bit 0.
- R8: Among enabled, asserted, not-yet-serviced sources, the lowest-numbered source is serviced first, at one per cycle.
- R9: A source that stays high is serviced once. It can be serviced again only after it has been low for at least one clock.
- R10: A source whose enable bit (address 2, bit n for source n) is clear produces no event.
- R11: The event strobe, source id and indices appear on the clock edge that samples the request, and the strobe lasts one cycle per event. Route entry n is at address 32+n.
- R12: After reset there is no event, the error output is low, and the enable mask reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| irq_lvl | input | N_SRC | Level interrupt inputs |
| evt_valid | output | 1 | Routed event strobe |
| evt_src | output | SRC_W | Serviced source number |
| evt_cpu | output | 8 | Target CPU index |
| evt_pin | output | 4 | Target interrupt pin index |
| route_err | output | 1 | Sticky unroutable-bitmap flag |

## Verification
The hardest cases to reach are the bitmap selectors that hold several set bits or none at all, under each of the four mode combinations. Random route words are used for this because they often contain zero nibbles and multi-bit nibbles, and each trial also picks a random configuration. The priority order and the rule that a held line is serviced once need several lines raised in the same cycle and kept high. Directed sequences provide this and then watch the order of strobes and the silence that follows.

// File: rtl/vroute_pkg.sv
package vroute_pkg;
  localparam int CPU_W  = 8;
  localparam int PIN_W  = 4;
  localparam int HALF_W = CPU_W / 2;
  localparam int ENT_W  = CPU_W + PIN_W;

  typedef struct packed {
    logic [PIN_W-1:0] pin;
    logic [CPU_W-1:0] cpu;
  } route_t;

  // position of the lowest set bit of a 4-bit map (0 when empty)
  function automatic logic [1:0] low_pos4(input logic [3:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (v[i]) r = 2'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/vroute_regs.sv
module vroute_regs
  import vroute_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              err_in,
  output logic              err_clr,
  output logic              cfg_pin_enc,
  output logic              cfg_cpu_enc,
  output logic [N_SRC-1:0]  src_en,
  input  logic [SRC_W-1:0]  rt_idx,
  output route_t            rt_entry
);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(3);

  route_t            route_mem [N_SRC];
  logic [1:0]        cfg_q;
  logic [N_SRC-1:0]  en_q;
  logic              rt_hit;
  logic [SRC_W-1:0]  rt_waddr;

  assign rt_hit   = addr[ADDR_W-1] && (int'(addr[SRC_W-1:0]) < N_SRC);
  assign rt_waddr = addr[SRC_W-1:0];
  assign err_clr  = wr && (addr == A_ERR);

  // route table: no reset so it maps onto a RAM
  always_ff @(posedge clk) begin
    if (wr && rt_hit) route_mem[rt_waddr] <= route_t'(wdata[ENT_W-1:0]);
  end

  assign rt_entry = route_mem[rt_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= 2'b00;
      en_q  <= '0;
    end else if (wr) begin
      if (addr == A_CFG) cfg_q <= wdata[1:0];
      if (addr == A_EN)  en_q  <= wdata[N_SRC-1:0];
    end
  end

  assign cfg_pin_enc = cfg_q[0];
  assign cfg_cpu_enc = cfg_q[1];
  assign src_en      = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= '0;
      if (rt_hit)               rdata <= DATA_W'(route_mem[rt_waddr]);
      else if (addr == A_FEAT)  rdata <= DATA_W'(2'b11);
      else if (addr == A_CFG)   rdata <= DATA_W'(cfg_q);
      else if (addr == A_EN)    rdata <= DATA_W'(en_q);
      else if (addr == A_ERR)   rdata <= DATA_W'(err_in);
    end
  end
endmodule

// File: rtl/vroute_arb.sv
module vroute_arb #(
  parameter int N_SRC = 32,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_lvl,
  input  logic [N_SRC-1:0] src_en,
  output logic             sel_valid,
  output logic [SRC_W-1:0] sel_idx
);
  logic [N_SRC-1:0] served_q;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] grant;

  assign pend = irq_lvl & src_en & ~served_q;

  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel_valid = 1'b1;
        sel_idx   = SRC_W'(i);
      end
    end
  end

  always_comb begin
    grant = '0;
    if (sel_valid) grant[sel_idx] = 1'b1;
  end

  // a line stays marked as serviced until it drops
  always_ff @(posedge clk) begin
    if (rst) served_q <= '0;
    else     served_q <= (served_q | grant) & irq_lvl;
  end
endmodule

// File: rtl/vroute_dec.sv
module vroute_dec
  import vroute_pkg::*;
#(
  parameter int N_SRC = 32,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_valid,
  input  logic [SRC_W-1:0] sel_idx,
  input  route_t           entry,
  input  logic             pin_enc,
  input  logic             cpu_enc,
  input  logic             err_clr,
  output logic             evt_valid,
  output logic [SRC_W-1:0] evt_src,
  output logic [CPU_W-1:0] evt_cpu,
  output logic [PIN_W-1:0] evt_pin,
  output logic             err
);
  logic [HALF_W-1:0] node_map, cpu_map;
  logic              cpu_ok, pin_ok, route_ok;
  logic [CPU_W-1:0]  cpu_idx;
  logic [PIN_W-1:0]  pin_idx;

  assign node_map = entry.cpu[CPU_W-1:HALF_W];
  assign cpu_map  = entry.cpu[HALF_W-1:0];
  assign cpu_ok   = cpu_enc || ((|node_map) && (|cpu_map));
  assign pin_ok   = pin_enc || (|entry.pin);
  assign route_ok = cpu_ok && pin_ok;

  assign cpu_idx = cpu_enc ? entry.cpu
                           : CPU_W'({low_pos4(node_map), low_pos4(cpu_map)});
  assign pin_idx = pin_enc ? entry.pin : PIN_W'(low_pos4(entry.pin));

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid <= 1'b0;
      evt_src   <= '0;
      evt_cpu   <= '0;
      evt_pin   <= '0;
    end else begin
      evt_valid <= sel_valid && route_ok;
      if (sel_valid && route_ok) begin
        evt_src <= sel_idx;
        evt_cpu <= cpu_idx;
        evt_pin <= pin_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         err <= 1'b0;
    else if (sel_valid && !route_ok) err <= 1'b1;
    else if (err_clr)                err <= 1'b0;
  end
endmodule

// File: rtl/vroute_top.sv
module vroute_top
  import vroute_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0]  irq_lvl,
  output logic              evt_valid,
  output logic [SRC_W-1:0]  evt_src,
  output logic [CPU_W-1:0]  evt_cpu,
  output logic [PIN_W-1:0]  evt_pin,
  output logic              route_err
);
  logic             cfg_pin_enc, cfg_cpu_enc, err_clr, sel_valid;
  logic [N_SRC-1:0] src_en;
  logic [SRC_W-1:0] sel_idx;
  route_t           rt_entry;

  vroute_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .err_in(route_err),
    .err_clr(err_clr), .cfg_pin_enc(cfg_pin_enc), .cfg_cpu_enc(cfg_cpu_enc),
    .src_en(src_en), .rt_idx(sel_idx), .rt_entry(rt_entry)
  );

  vroute_arb #(.N_SRC(N_SRC)) u_arb (
    .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .src_en(src_en),
    .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  vroute_dec #(.N_SRC(N_SRC)) u_dec (
    .clk(clk), .rst(rst), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .entry(rt_entry), .pin_enc(cfg_pin_enc), .cpu_enc(cfg_cpu_enc),
    .err_clr(err_clr), .evt_valid(evt_valid), .evt_src(evt_src),
    .evt_cpu(evt_cpu), .evt_pin(evt_pin), .err(route_err)
  );
endmodule

// File: rtl/vroute_chk.sv
module vroute_chk #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N_SRC-1:0]  irq_lvl,
  input logic [N_SRC-1:0]  src_en,
  input logic              cfg_pin_enc,
  input logic              cfg_cpu_enc,
  input logic              evt_valid,
  input logic [7:0]        evt_cpu,
  input logic [3:0]        evt_pin,
  input logic              route_err
);
  a_r1_feat_ro: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == '0) |=> (reg_rdata == DATA_W'(3)));

  a_r3_bitmap_cpu_range: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !$past(cfg_cpu_enc)) |-> (evt_cpu < 8'd16));

  a_r4_bitmap_pin_range: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !$past(cfg_pin_enc)) |-> (evt_pin < 4'd4));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (route_err && !(reg_wr && reg_addr == ADDR_W'(3))) |=> route_err);

  a_r10_needs_enable: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(|(irq_lvl & src_en)));

  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> (!evt_valid && !route_err));
endmodule

bind vroute_top vroute_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_lvl(irq_lvl), .src_en(src_en),
  .cfg_pin_enc(cfg_pin_enc), .cfg_cpu_enc(cfg_cpu_enc), .evt_valid(evt_valid),
  .evt_cpu(evt_cpu), .evt_pin(evt_pin), .route_err(route_err)
);

// File: tb/vroute_top_test.sv
module vroute_top_test;
  localparam int CLK_PER = 10;
  localparam int N_SRC   = 32;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [N_SRC-1:0]  irq_lvl = '0;
  logic              evt_valid, route_err;
  logic [4:0]        evt_src;
  logic [7:0]        evt_cpu;
  logic [3:0]        evt_pin;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  vroute_top uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lvl(irq_lvl),
    .evt_valid(evt_valid), .evt_src(evt_src), .evt_cpu(evt_cpu),
    .evt_pin(evt_pin), .route_err(route_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic int lo4(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic bit m_ok(input logic [11:0] e, input logic [1:0] c);
    bit cok, pok;
    cok = c[1] || (e[7:4] != 0 && e[3:0] != 0);
    pok = c[0] || (e[11:8] != 0);
    return cok && pok;
  endfunction

  function automatic logic [7:0] m_cpu(input logic [11:0] e, input logic [1:0] c);
    if (c[1]) return e[7:0];
    return 8'(lo4(e[7:4]) * 4 + lo4(e[3:0]));
  endfunction

  function automatic logic [3:0] m_pin(input logic [11:0] e, input logic [1:0] c);
    if (c[0]) return e[11:8];
    return 4'(lo4(e[11:8]));
  endfunction

  // raise one line, capture the event on the following negedge, drop it
  task automatic fire(input int s, input logic [11:0] e, input logic [1:0] c, input string tag);
    @(negedge clk);
    irq_lvl = '0; irq_lvl[s] = 1'b1;
    @(negedge clk);
    irq_lvl = '0;
    if (m_ok(e, c)) begin
      chk({tag, " R11 valid"}, evt_valid, 1);
      chk({tag, " R8 src"}, evt_src, s);
      chk({tag, (c[1] ? " R6 cpu" : " R3 cpu")}, evt_cpu, m_cpu(e, c));
      chk({tag, (c[0] ? " R5 pin" : " R4 pin")}, evt_pin, m_pin(e, c));
    end else begin
      chk({tag, " R7 dropped"}, evt_valid, 0);
      chk({tag, " R7 err set"}, route_err, 1);
    end
    @(negedge clk);
    chk({tag, " R11 one-cycle strobe"}, evt_valid, 0);
    if (!m_ok(e, c)) begin
      wr(3, 0);
      chk({tag, " R7 err cleared"}, route_err, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] e;
    logic [1:0]  c;
    int s;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 no event", evt_valid, 0);
    chk("R12 no error", route_err, 0);
    rd(2, d); chk("R12 enable mask", d, 0);
    rd(1, d); chk("R2 cfg reset", d, 0);

    // feature word
    rd(0, d); chk("R1 feature", d, 3);
    wr(0, 0);
    rd(0, d); chk("R1 feature after write", d, 3);

    // configuration read-back
    wr(1, 2); rd(1, d); chk("R2 cfg rw", d, 2);
    wr(1, 1); rd(1, d); chk("R2 cfg rw", d, 1);
    wr(1, 0);

    // disabled source
    wr(32 + 5, 12'h111);
    wr(2, 32'hFFFF_FFDF);
    @(negedge clk); irq_lvl[5] = 1'b1;
    @(negedge clk); chk("R10 disabled no event", evt_valid, 0);
    @(negedge clk); chk("R10 disabled no event", evt_valid, 0);
    irq_lvl = '0;
    wr(2, 32'hFFFF_FFFF);

    // priority order and single service of held lines
    wr(1, 3);
    wr(32 + 3, 12'h0A3); wr(32 + 7, 12'h1B7); wr(32 + 20, 12'hF14);
    @(negedge clk); irq_lvl = (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 20);
    @(negedge clk); chk("R8 first", evt_src, 3); chk("R6 cpu", evt_cpu, 8'hA3);
    @(negedge clk); chk("R8 second", evt_src, 7); chk("R5 pin", evt_pin, 1);
    @(negedge clk); chk("R8 third", evt_src, 20); chk("R5 pin", evt_pin, 15);
    @(negedge clk); chk("R9 held lines not repeated", evt_valid, 0);
    @(negedge clk); chk("R9 held lines not repeated", evt_valid, 0);
    irq_lvl = '0;
    @(negedge clk);
    fire(3, 12'h0A3, 2'b11, "R9 rearm");

    // bitmap decode with several bits set
    wr(1, 0);
    wr(32 + 9, 12'hAC6);
    fire(9, 12'hAC6, 2'b00, "directed bitmap");
    chk("R3 multi-bit cpu", evt_cpu, 9);

    // empty bitmap: error is sticky until cleared
    wr(32 + 4, 12'h110);
    @(negedge clk); irq_lvl[4] = 1'b1;
    @(negedge clk); irq_lvl = '0;
    chk("R7 drop", evt_valid, 0);
    repeat (3) @(negedge clk);
    chk("R7 sticky", route_err, 1);
    rd(3, d); chk("R7 err readable", d, 1);
    wr(3, 0); chk("R7 cleared", route_err, 0);

    // random mix of routes and modes
    for (int t = 0; t < 300; t++) begin
      s = int'($urandom % N_SRC);
      e = 12'($urandom);
      c = 2'($urandom);
      wr(1, 32'(c));
      wr(32 + s, 32'(e));
      rd(32 + s, d); chk("R11 route readback", d, 32'(e));
      fire(s, e, c, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule